// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Receiver

This block turns an asynchronous serial bit stream into parallel words. It runs from a receive clock at a fixed multiple (sixteen by default) of the bit rate. The line first passes through a synchronizer. A bit engine then waits for a falling start edge and times each bit from that edge. It confirms the start bit at mid-bit and collects five to eight data bits, least significant first. An optional parity bit and the stop bit follow.

When the stop bit is sampled, the finished word moves into a holding register and a word-available flag is raised. The engine is then free for the next frame while software reads the word. Parity, framing and overrun conditions are captured alongside the word. They appear on two error pins and in a status register that the bus can read. A four-signal select decode qualifies bus reads. A read of the data register clears the word-available flag.

Top module: `uart_rx_dbuf`

## Requirements
- R1: After reset, rx_avail, rx_err_oe_pe and rx_frame_err are 0 and the status register reads 0x00.
- R2: If edge 0 is the first rising clock edge with rx_serial low, the start bit is sampled at edge 10. Each later bit is sampled 16 edges after the one before it. With k = data bits + parity bit + 1, the stop bit is sampled at edge 10+16k, and rx_avail is 1 right after that edge.
- R3: A start bit that is high again at its mid-bit sample is discarded. No word is loaded, and the receiver waits for the next falling edge.
- R4: cfg_wlen selects 5, 6, 7 or 8 data bits for codes 0, 1, 2 and 3. The word is right-justified in the data register, and the bits above the word length read as 0.
- R5: A bus read takes place only when bus_en_a=1, bus_en_c=1, bus_rnw=1 and bus_en_b_n=0. bus_addr=0 selects the data register and bus_addr=1 selects status. A read of the data register clears rx_avail at that clock edge. A read with any select inactive leaves rx_avail set.
- R6: If rx_avail is still set when a new word is loaded, and no data read happens at that same edge, the overrun flag is set. A load while rx_avail is clear leaves overrun at 0.
- R7: With cfg_par_en=1, a parity bit follows the data bits. cfg_par_odd=0 selects even parity and 1 selects odd. A mismatch sets the parity flag at the load. With parity disabled there is no parity bit and the flag is 0.
- R8: A stop bit sampled as 0 sets rx_frame_err at the load.
- R9: rx_err_oe_pe is the OR of the overrun and parity flags. The status register holds rx_avail in bit 0, overrun in bit 1, parity in bit 2 and framing in bit 3. Bits 7:4 read as 0.
- R10: The overrun, parity and framing flags change only when a word is loaded. They keep their values until the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock, OVS times the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_serial | input | 1 | Serial line, idle high |
| cfg_wlen | input | 2 | Word length code, 5 + code data bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| bus_en_a | input | 1 | Bus select, active high |
| bus_en_b_n | input | 1 | Bus select, active low |
| bus_en_c | input | 1 | Bus select, active high |
| bus_rnw | input | 1 | 1 = read cycle |
| bus_addr | input | 1 | 0 = data register, 1 = status register |
| bus_rdata | output | DATA_W | Read data, combinational from bus_addr |
| rx_avail | output | 1 | Word waiting in the holding register |
| rx_err_oe_pe | output | 1 | Overrun OR parity error |
| rx_frame_err | output | 1 | Framing error of the last word |

## Verification
Every result is due a fixed number of edges after the line falls. The synchronizer and the start qualification together take ten edges, and each further bit takes sixteen. rx_avail and the error pins therefore change right after edge 10+16k. The bench counts falling edges from the moment it drives the start bit. It samples the outputs at count 10+16k, before the load, and again at 11+16k, after it, so a load one edge early or late is caught. Bus reads are sampled combinationally after the selects settle. The cleared flag is checked at the next falling edge.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_PAR,
      RX_STOP
   } rx_state_e;

   localparam int WLEN_W = 2;

   typedef struct packed {
      logic [WLEN_W-1:0] wlen;
      logic              par_en;
      logic              par_odd;
   } rx_cfg_t;

   // status register bit positions
   localparam int ST_AVAIL = 0;
   localparam int ST_OVR   = 1;
   localparam int ST_PAR   = 2;
   localparam int ST_FRM   = 3;
   localparam int ST_BITS  = 4;

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign dout = din;
      end else begin : g_chain
         logic [STAGES-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q <= '1;
            end else if (STAGES == 1) begin
               q <= din;
            end else begin
               q <= {q[STAGES-2:0], din};
            end
         end
         assign dout = q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/rx_bit_engine.sv
module rx_bit_engine
   import uart_rx_pkg::*;
#(
   parameter int OVS    = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line,
   input  rx_cfg_t           cfg,
   output logic              load,
   output logic [DATA_W-1:0] word,
   output logic              perr,
   output logic              ferr
);
   localparam int CNT_W    = $clog2(OVS);
   localparam int IDX_W    = $clog2(DATA_W + 1);
   localparam int MID      = OVS / 2 - 1;
   localparam int MIN_BITS = DATA_W - (2 ** WLEN_W - 1);

   localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(MID);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVS - 1);

   rx_state_e         state;
   logic [CNT_W-1:0]  cnt;
   logic [IDX_W-1:0]  idx;
   logic [IDX_W-1:0]  nbits;
   logic [DATA_W-1:0] shreg;
   logic              par_acc;
   logic              perr_q;
   rx_cfg_t           cfg_q;
   logic              tick;

   assign tick  = (cnt == CNT_MID);
   assign nbits = IDX_W'(MIN_BITS) + IDX_W'(cfg_q.wlen);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= RX_IDLE;
         cnt     <= '0;
         idx     <= '0;
         shreg   <= '0;
         par_acc <= 1'b0;
         perr_q  <= 1'b0;
         cfg_q   <= '0;
      end else if (state == RX_IDLE) begin
         if (!line) begin
            state <= RX_START;
            cnt   <= '0;
            cfg_q <= cfg;
         end
      end else begin
         cnt <= (cnt == CNT_LAST) ? '0 : cnt + 1'b1;
         if (tick) begin
            case (state)
               RX_START: begin
                  if (line) begin
                     state <= RX_IDLE;
                  end else begin
                     state   <= RX_DATA;
                     idx     <= '0;
                     shreg   <= '0;
                     par_acc <= 1'b0;
                     perr_q  <= 1'b0;
                  end
               end
               RX_DATA: begin
                  shreg   <= {line, shreg[DATA_W-1:1]};
                  par_acc <= par_acc ^ line;
                  idx     <= idx + 1'b1;
                  if (idx == nbits - 1'b1) begin
                     state <= cfg_q.par_en ? RX_PAR : RX_STOP;
                  end
               end
               RX_PAR: begin
                  perr_q <= par_acc ^ line ^ cfg_q.par_odd;
                  state  <= RX_STOP;
               end
               RX_STOP: begin
                  state <= RX_IDLE;
               end
               default: state <= RX_IDLE;
            endcase
         end
      end
   end

   assign load = (state == RX_STOP) && tick;
   assign word = shreg >> (IDX_W'(DATA_W) - nbits);
   assign perr = perr_q;
   assign ferr = ~line;
endmodule

// File: rtl/rx_hold_reg.sv
module rx_hold_reg #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] word_in,
   input  logic              perr_in,
   input  logic              ferr_in,
   input  logic              rd_clr,
   output logic [DATA_W-1:0] data_q,
   output logic              avail,
   output logic              ovr,
   output logic              par_err,
   output logic              frm_err
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q  <= '0;
         avail   <= 1'b0;
         ovr     <= 1'b0;
         par_err <= 1'b0;
         frm_err <= 1'b0;
      end else if (load) begin
         data_q  <= word_in;
         avail   <= 1'b1;
         ovr     <= avail & ~rd_clr;
         par_err <= perr_in;
         frm_err <= ferr_in;
      end else if (rd_clr) begin
         avail <= 1'b0;
      end
   end
endmodule

// File: rtl/rx_bus_port.sv
module rx_bus_port
   import uart_rx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic               en_a,
   input  logic               en_b_n,
   input  logic               en_c,
   input  logic               rnw,
   input  logic               addr,
   input  logic [DATA_W-1:0]  data_q,
   input  logic [ST_BITS-1:0] status,
   output logic [DATA_W-1:0]  rdata,
   output logic               rd_clr
);
   logic              rd_sel;
   logic [DATA_W-1:0] stat_w;

   generate
      if (DATA_W > ST_BITS) begin : g_pad
         assign stat_w = {{(DATA_W - ST_BITS){1'b0}}, status};
      end else begin : g_nopad
         assign stat_w = status[DATA_W-1:0];
      end
   endgenerate

   assign rd_sel = en_a & en_c & rnw & ~en_b_n;
   assign rd_clr = rd_sel & ~addr;
   assign rdata  = addr ? stat_w : data_q;
endmodule

// File: rtl/uart_rx_dbuf.sv
module uart_rx_dbuf
   import uart_rx_pkg::*;
#(
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2,
   parameter int DATA_W      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_serial,
   input  logic [1:0]        cfg_wlen,
   input  logic              cfg_par_en,
   input  logic              cfg_par_odd,
   input  logic              bus_en_a,
   input  logic              bus_en_b_n,
   input  logic              bus_en_c,
   input  logic              bus_rnw,
   input  logic              bus_addr,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              rx_avail,
   output logic              rx_err_oe_pe,
   output logic              rx_frame_err
);
   generate
      if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
         $error("OVS must be even and at least 4");
      end
      if (DATA_W < 2 ** WLEN_W || DATA_W < ST_BITS) begin : g_bad_width
         $error("DATA_W too small for word length code and status");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("SYNC_STAGES must not be negative");
      end
   endgenerate

   logic              line_s;
   rx_cfg_t           cfg;
   logic              eng_load;
   logic [DATA_W-1:0] eng_word;
   logic              eng_perr;
   logic              eng_ferr;
   logic              rd_clr;
   logic [DATA_W-1:0] hold_data;
   logic              hold_ovr;
   logic              hold_par;
   logic              hold_frm;
   logic [ST_BITS-1:0] status;

   assign cfg = '{wlen: cfg_wlen, par_en: cfg_par_en, par_odd: cfg_par_odd};

   rx_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (rx_serial),
      .dout (line_s)
   );

   rx_bit_engine #(.OVS(OVS), .DATA_W(DATA_W)) i_engine (
      .clk  (clk),
      .rst_n(rst_n),
      .line (line_s),
      .cfg  (cfg),
      .load (eng_load),
      .word (eng_word),
      .perr (eng_perr),
      .ferr (eng_ferr)
   );

   rx_hold_reg #(.DATA_W(DATA_W)) i_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (eng_load),
      .word_in(eng_word),
      .perr_in(eng_perr),
      .ferr_in(eng_ferr),
      .rd_clr (rd_clr),
      .data_q (hold_data),
      .avail  (rx_avail),
      .ovr    (hold_ovr),
      .par_err(hold_par),
      .frm_err(hold_frm)
   );

   always_comb begin
      status           = '0;
      status[ST_AVAIL] = rx_avail;
      status[ST_OVR]   = hold_ovr;
      status[ST_PAR]   = hold_par;
      status[ST_FRM]   = hold_frm;
   end

   rx_bus_port #(.DATA_W(DATA_W)) i_bus (
      .en_a  (bus_en_a),
      .en_b_n(bus_en_b_n),
      .en_c  (bus_en_c),
      .rnw   (bus_rnw),
      .addr  (bus_addr),
      .data_q(hold_data),
      .status(status),
      .rdata (bus_rdata),
      .rd_clr(rd_clr)
   );

   assign rx_err_oe_pe = hold_ovr | hold_par;
   assign rx_frame_err = hold_frm;
endmodule

// File: rtl/uart_rx_dbuf_chk.sv
module uart_rx_dbuf_chk (
   input logic clk,
   input logic rst_n,
   input logic line_s,
   input logic eng_load,
   input logic rd_clr,
   input logic hold_ovr,
   input logic rx_avail,
   input logic rx_err_oe_pe,
   input logic rx_frame_err
);
   a_r2_load_sets_avail: assert property (@(posedge clk) disable iff (!rst_n)
      eng_load |=> rx_avail);

   a_r1_avail_needs_load: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_avail) |-> $past(eng_load));

   a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr && !eng_load) |=> !rx_avail);

   a_r6_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_load && rx_avail && !rd_clr) |=> hold_ovr);

   a_r8_stop_low: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_load && !line_s) |=> rx_frame_err);

   a_r10_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !eng_load |=> ($stable(rx_err_oe_pe) && $stable(rx_frame_err)));
endmodule

bind uart_rx_dbuf uart_rx_dbuf_chk i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .line_s      (line_s),
   .eng_load    (eng_load),
   .rd_clr      (rd_clr),
   .hold_ovr    (hold_ovr),
   .rx_avail    (rx_avail),
   .rx_err_oe_pe(rx_err_oe_pe),
   .rx_frame_err(rx_frame_err)
);

// File: tb/test_uart_rx_dbuf.sv
`timescale 1ns/1ps
module test_uart_rx_dbuf;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_serial = 1'b1;
   logic [1:0] cfg_wlen = 2'd3;
   logic       cfg_par_en = 1'b0;
   logic       cfg_par_odd = 1'b0;
   logic       bus_en_a = 1'b0;
   logic       bus_en_b_n = 1'b1;
   logic       bus_en_c = 1'b0;
   logic       bus_rnw = 1'b0;
   logic       bus_addr = 1'b0;
   logic [7:0] bus_rdata;
   logic       rx_avail;
   logic       rx_err_oe_pe;
   logic       rx_frame_err;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   uart_rx_dbuf i_uart_rx_dbuf (
      .clk(clk), .rst_n(rst_n), .rx_serial(rx_serial),
      .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
      .bus_en_a(bus_en_a), .bus_en_b_n(bus_en_b_n), .bus_en_c(bus_en_c),
      .bus_rnw(bus_rnw), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
      .rx_avail(rx_avail), .rx_err_oe_pe(rx_err_oe_pe), .rx_frame_err(rx_frame_err)
   );

   task automatic chk(string req, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // one bus read; selects given explicitly so bad decodes can be tried
   task automatic bus_read(bit a, bit b_n, bit c, bit rnw, bit addr, output logic [7:0] val);
      @(negedge clk);
      bus_en_a = a; bus_en_b_n = b_n; bus_en_c = c; bus_rnw = rnw; bus_addr = addr;
      #1 val = bus_rdata;
      @(negedge clk);
      bus_en_a = 1'b0; bus_en_b_n = 1'b1; bus_en_c = 1'b0; bus_rnw = 1'b0; bus_addr = 1'b0;
   endtask

   // drive one frame and check the load timing and flags (R2, R6, R7, R8, R9)
   task automatic send_frame(int nb, logic [7:0] d, bit pen, bit podd, bit flip, bit stop_v);
      logic b [0:11];
      int   k;
      bit   prior, par, exp_oe, exp_pe;
      k = nb + (pen ? 1 : 0) + 1;
      par = podd;
      for (int i = 0; i < nb; i++) par ^= d[i];
      b[0] = 1'b0;
      for (int i = 0; i < nb; i++) b[1+i] = d[i];
      if (pen) b[1+nb] = par ^ flip;
      b[k] = stop_v;
      @(negedge clk);
      cfg_wlen = 2'(nb - 5); cfg_par_en = pen; cfg_par_odd = podd;
      prior  = rx_avail;
      exp_oe = prior;
      exp_pe = pen & flip;
      for (int m = 0; m < 16 * (k + 1); m++) begin
         if (m == 10 + 16 * k) chk("R2 avail before stop sample", rx_avail, prior);
         if (m == 11 + 16 * k) begin
            chk("R2 avail after stop sample", rx_avail, 1);
            chk("R9 shared error pin", rx_err_oe_pe, exp_oe | exp_pe);
            chk("R8 framing pin", rx_frame_err, !stop_v);
         end
         rx_serial = (m / 16 == k && m % 16 >= 9) ? 1'b1 : b[m / 16];
         @(negedge clk);
      end
      rx_serial = 1'b1;
   endtask

   task automatic read_word(logic [7:0] exp_data, logic [7:0] exp_stat, string req);
      logic [7:0] v;
      bus_read(1, 0, 1, 1, 1, v);
      chk({req, " status"}, v, exp_stat);
      bus_read(1, 0, 1, 1, 0, v);
      chk({req, " data"}, v, exp_data);
      chk("R5 data read clears avail", rx_avail, 0);
   endtask

   task automatic t_reset();
      logic [7:0] v;
      chk("R1 avail", rx_avail, 0);
      chk("R1 err pin", rx_err_oe_pe, 0);
      chk("R1 frame pin", rx_frame_err, 0);
      bus_read(1, 0, 1, 1, 1, v);
      chk("R1 status", v, 8'h00);
   endtask

   task automatic t_lengths();
      send_frame(8, 8'hA5, 0, 0, 0, 1); read_word(8'hA5, 8'h01, "R4 8 bits");
      send_frame(5, 8'h13, 0, 0, 0, 1); read_word(8'h13, 8'h01, "R4 5 bits");
      send_frame(6, 8'h2E, 0, 0, 0, 1); read_word(8'h2E, 8'h01, "R4 6 bits");
      send_frame(7, 8'h5B, 0, 0, 0, 1); read_word(8'h5B, 8'h01, "R4 7 bits");
   endtask

   task automatic t_parity();
      send_frame(8, 8'h37, 1, 0, 0, 1); read_word(8'h37, 8'h01, "R7 even good");
      send_frame(8, 8'h37, 1, 1, 0, 1); read_word(8'h37, 8'h01, "R7 odd good");
      send_frame(7, 8'h41, 1, 0, 1, 1); read_word(8'h41, 8'h05, "R7 even bad");
      chk("R10 parity pin held after read", rx_err_oe_pe, 1);
      send_frame(6, 8'h15, 1, 1, 1, 1); read_word(8'h15, 8'h05, "R7 odd bad");
      send_frame(8, 8'hFF, 0, 0, 0, 1); read_word(8'hFF, 8'h01, "R10 parity cleared by load");
   endtask

   task automatic t_framing();
      send_frame(8, 8'h3C, 0, 0, 0, 0); read_word(8'h3C, 8'h09, "R8 bad stop");
      chk("R10 frame pin held after read", rx_frame_err, 1);
      send_frame(8, 8'hC3, 0, 0, 0, 1); read_word(8'hC3, 8'h01, "R10 framing cleared by load");
   endtask

   task automatic t_overrun();
      logic [7:0] v;
      send_frame(8, 8'h11, 0, 0, 0, 1);
      bus_read(0, 0, 1, 1, 0, v);
      chk("R5 en_a low no clear", rx_avail, 1);
      bus_read(1, 1, 1, 1, 0, v);
      chk("R5 en_b_n high no clear", rx_avail, 1);
      bus_read(1, 0, 0, 1, 0, v);
      chk("R5 en_c low no clear", rx_avail, 1);
      bus_read(1, 0, 1, 0, 0, v);
      chk("R5 write cycle no clear", rx_avail, 1);
      send_frame(8, 8'h22, 0, 0, 0, 1);
      read_word(8'h22, 8'h03, "R6 overrun");
      send_frame(8, 8'h33, 0, 0, 0, 1);
      read_word(8'h33, 8'h01, "R6 no overrun after read");
   endtask

   task automatic t_glitch();
      @(negedge clk);
      rx_serial = 1'b0;
      repeat (4) @(negedge clk);
      rx_serial = 1'b1;
      repeat (40) @(negedge clk);
      chk("R3 glitch loads nothing", rx_avail, 0);
      send_frame(8, 8'h6D, 0, 0, 0, 1); read_word(8'h6D, 8'h01, "R3 recovers after glitch");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      t_reset();
      t_lengths();
      t_parity();
      t_framing();
      t_overrun();
      t_glitch();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule